// File: doc/BRIEF.md
# Sequential Keypad Combination Lock

A ten-button code lock. Four of the buttons form the code and must be pressed one after another in a fixed order. The other six are abort buttons. Progress through the code is held in a one-hot step register. A press moves the lock forward by one step only when it is the code button expected at the current step. A code button pressed out of turn is ignored, and the progress made so far is kept. Any abort button sends the lock straight back to its start step. This includes the open step, so pressing an abort button while the lock is open locks it again at once.

Each raw button line passes through a two-flop synchroniser and then a per-button debounce counter. A level change is accepted only after the synchronised line has held its new value for 2^DEB_BITS consecutive clock cycles. Only the rising edge of a debounced level counts as a press, so contact bounce and a held button each yield exactly one press event. The code buttons are `key_raw[0]` to `key_raw[3]`, entered in that order. The abort buttons are `key_raw[4]` to `key_raw[9]`.

Top module: `keyseq_lock`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `step` is 5'b00001 and `unlock` is 0.
- R2: `step` always has exactly one bit set; bit i means that i code buttons have been accepted (i = 0..4).
- R3: A debounced press of code button `key_raw[i]` while `step[i]` is set (i = 0..3) moves `step` to bit i+1.
- R4: A press of a code button other than the expected one, including any code button while at bit 4, leaves `step` unchanged.
- R5: A debounced press of any abort button `key_raw[9:4]` returns `step` to 5'b00001 from every step, including the open step.
- R6: `unlock` is high exactly when `step[4]` is set.
- R7: A raw button level held for fewer than 2^DEB_BITS cycles after synchronisation is not accepted and has no effect on `step`.
- R8: A button held down produces a single press event; holding it does not repeat the action.
- R9: When press events start in the same cycle, an abort button among them returns `step` to 5'b00001; two or more code buttons without an abort button leave `step` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_raw | input | 10 | Raw active-high button lines; [3:0] code buttons in order, [9:4] abort buttons |
| unlock | output | 1 | High while the lock is open |
| step | output | 5 | One-hot progress; bit i = i code buttons accepted |

## Verification
The main sweep drives the lock to every step from 0 to 4 and then presses each of the ten buttons once. This separates a correct advance from an ignored out-of-turn code button and from an abort, and it covers the open step against every button. Short pulses that end before the debounce window, together with a long hold, separate rejected glitches from a single accepted press. Simultaneous pairs of buttons show that an abort wins over a code button and that two code buttons together are ignored.

// File: rtl/keyseq_lock.sv
module keyseq_lock #(
  parameter int DEB_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [9:0] key_raw,
  output logic       unlock,
  output logic [4:0] step
);
  localparam int NKEY  = 10;
  localparam int NCODE = 4;
  localparam int NSTEP = NCODE + 1;

  logic [NKEY-1:0] sync_a, sync_b, deb, deb_q, rise;
  logic            abort, advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      deb_q  <= '0;
    end else begin
      sync_a <= key_raw;
      sync_b <= sync_a;
      deb_q  <= deb;
    end
  end

  for (genvar g = 0; g < NKEY; g++) begin : g_deb
    logic [DEB_BITS-1:0] cnt;
    logic                lvl;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (sync_b[g] == lvl) begin
        cnt <= '0;
      end else if (&cnt) begin
        cnt <= '0;
        lvl <= sync_b[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign deb[g] = lvl;
  end

  assign rise    = deb & ~deb_q;
  assign abort   = |rise[NKEY-1:NCODE];
  assign advance = (rise[NCODE-1:0] != '0) && (rise[NCODE-1:0] == step[NCODE-1:0]);

  always_ff @(posedge clk) begin
    if (rst || abort) step <= NSTEP'(1);
    else if (advance) step <= {step[NSTEP-2:0], 1'b0};
  end

  assign unlock = step[NSTEP-1];

  a_r1_reset_state: assert property (@(posedge clk) rst |=> step == NSTEP'(1) && !unlock);
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $countones(step) == 1);
  a_r3_advance_one: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step) && !$past(abort)) |-> step == {$past(step[NSTEP-2:0]), 1'b0});
  a_r5_abort_home: assert property (@(posedge clk) disable iff (rst) abort |=> step == NSTEP'(1));
  a_r6_open_after_last: assert property (@(posedge clk) disable iff (rst) $rose(unlock) |-> $past(step[NSTEP-2]));
  a_r8_single_event: assert property (@(posedge clk) disable iff (rst) (|rise) |=> (rise & $past(rise)) == '0);
  a_r9_multi_code_ignored: assert property (@(posedge clk) disable iff (rst)
    (!abort && $countones(rise[NCODE-1:0]) > 1) |=> $stable(step));
endmodule

// File: tb/test_keyseq_lock.sv
module test_keyseq_lock;
  localparam int DB   = 2;
  localparam int WAIT = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] key_raw = '0;
  logic       unlock;
  logic [4:0] step;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  keyseq_lock #(.DEB_BITS(DB)) i_keyseq_lock (
    .clk(clk), .rst(rst), .key_raw(key_raw), .unlock(unlock), .step(step)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [9:0] m);
    key_raw = m;
    idle(WAIT);
    key_raw = '0;
    idle(WAIT);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic check(input string req, input int exp);
    logic [4:0] es;
    es = 5'(1 << exp);
    vectors++;
    if (step !== es || unlock !== (exp == 4)) begin
      errors++;
      $display("FAIL %s: step=%b unlock=%b expected step=%b unlock=%b", req, step, unlock, es, exp == 4);
    end
  endtask

  initial begin
    int guard = 0;
    while (guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle(2);
    check("R1 during reset", 0);
    do_reset();
    check("R1 after reset", 0);

    for (int s = 0; s <= 4; s++) begin
      for (int k = 0; k < 10; k++) begin
        int exp;
        string tag;
        do_reset();
        for (int j = 0; j < s; j++) press(10'(1 << j));
        check("R3 reach step", s);
        press(10'(1 << k));
        if (k >= 4) begin exp = 0; tag = "R5 abort"; end
        else if (k == s) begin exp = s + 1; tag = "R3 advance"; end
        else begin exp = s; tag = "R4 out of turn ignored"; end
        check(tag, exp);
        if (exp == 4) check("R6 open after last code key", 4);
      end
    end

    do_reset();
    for (int n = 0; n < 5; n++) begin
      key_raw = 10'b1;
      idle(3);
      key_raw = '0;
      idle(3);
    end
    idle(WAIT);
    check("R7 short pulses rejected", 0);

    key_raw = 10'b1;
    idle(60);
    check("R8 held key single event", 1);
    key_raw = '0;
    idle(WAIT);
    press(10'b10);
    check("R8 next key after hold", 2);

    do_reset();
    press(10'b00_0010_0001);
    check("R9 abort with code key", 0);
    press(10'b1);
    press(10'b00_0000_0110);
    check("R9 two code keys ignored", 1);
    press(10'b00_0000_0010);
    press(10'b10_0000_0100);
    check("R9 abort wins at step 2", 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule